// File: doc/BRIEF.md
# Protected RTC register interface

This block is the bus-facing register front end of a real-time clock. It sits between a 32-bit register bus, clocked by the fast bus clock, and a calendar counter core that runs on a slow RTC clock. Software reads and writes word-aligned registers through it. The counting itself happens in the separate core. The front end drives that core with the programmed time, date, prescaler and hour-format values, a one-cycle load strobe and a freeze level. It receives the running time and date back from the core and keeps them as shadow copies.

Every register that changes the calendar is write-protected. Software opens the protection with a two-byte key sequence. Calendar and prescaler values are then accepted only inside an initialization window, which is entered through a request/acknowledge handshake across the two clock domains. When the window closes, the new values are loaded into the counters. A synchronized flag then marks the shadow copies as current once they have been refreshed from the running counters.

Top module: `rtcif_top`

## Requirements
- R1: After reset the block is locked, the status register reads 0, the control register reads 0 and the prescaler reads 0x007F00FF. The synchronized flag then sets by itself once the first shadow refresh completes.
- R2: Protection opens only when 0xCA is written to the low byte of the key register (byte offset 0x24) and the very next bus write puts 0x53 there. Any other bus write in between, or the wrong order, leaves the block locked. Repeating 0xCA restarts the sequence.
- R3: A key write of any byte other than 0xCA or a correctly placed 0x53 (0xFF is the usual choice) locks the block again at once.
- R4: While the block is locked, writes to time (0x00), date (0x04), status (0x0C), prescaler (0x10) and control (0x18) have no effect, and those registers read back unchanged.
- R5: Time, date and prescaler writes take effect only while the block is unlocked, the init request (status bit 7) is set and init-active (status bit 6) is set. The accepted time and date values appear on the calendar outputs. The control register needs only the unlock.
- R6: Setting status bit 7 raises status bit 6 and the freeze output only after the request has crossed into the RTC clock domain, so bit 6 is still 0 on the cycle after the write. Clearing bit 7 drops bit 6 again.
- R7: A status write with bit 5 equal to 0 clears the synchronized flag (status bit 5) from the next cycle on. A write with bit 5 equal to 1 leaves the flag alone. The flag sets again once the shadow copies returned at offsets 0x00 and 0x04 hold fresh counter values.
- R8: When init mode ends, exactly one load strobe carries the programmed time and date into the counter core while the freeze output is low. The synchronized flag is not set until after that load, so the readback then holds the loaded values.
- R9: Status bit 4 reads 1 exactly when the year field of the shadow date (bits 23:16) is nonzero.
- R10: Control bit 6 selects the hour format (0 = 24-hour, 1 = 12-hour) and drives the format output. All other control bits read 0.
- R11: The key register and unmapped offsets (for example 0x08 and 0x3C) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| rtc_clk | input | 1 | Slow RTC clock |
| rtc_rst_n | input | 1 | Active-low reset, RTC domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cal_time | output | 23 | Programmed time value for the counter core |
| cal_date | output | 24 | Programmed date value for the counter core |
| cal_prescale | output | 23 | Programmed prescaler value |
| cal_fmt12 | output | 1 | Hour format, 1 = 12-hour |
| cal_load | output | 1 | One RTC-cycle load strobe into the counters |
| cal_freeze | output | 1 | Counters held while high (init mode active) |
| cnt_time | input | 23 | Running time from the counter core |
| cnt_date | input | 24 | Running date from the counter core |

## Verification
If the unlock sequencer is in the wrong state, the next protected write reads back wrong on the very next bus cycle. That is why the vector table alternates writes with readbacks of the same register. If the handshake across the clock domains fails, status bit 6 or bit 5 never rises, or the freeze and load outputs stay stuck. This shows within a few RTC periods, and polling with a bounded wait turns it into a failed check. If the shadow refresh is ordered wrongly against the load, the synchronized flag rises while the time readback still lies outside the small window just after the loaded value.

// File: rtl/rtcif_pkg.sv
`timescale 1ns/100ps
package rtcif_pkg;

    // Byte offsets of the mapped registers
    localparam logic [7:0] OFS_TIME = 8'h00;
    localparam logic [7:0] OFS_DATE = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_PRE  = 8'h10;
    localparam logic [7:0] OFS_CTRL = 8'h18;
    localparam logic [7:0] OFS_KEY  = 8'h24;

    // Status and control bit positions
    localparam int STAT_REQ_BIT  = 7;
    localparam int STAT_ACT_BIT  = 6;
    localparam int STAT_SYNC_BIT = 5;
    localparam int STAT_SET_BIT  = 4;
    localparam int CTRL_FMT_BIT  = 6;

    // Unlock key bytes
    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

endpackage

// File: rtl/rtcif_sync2.sv
`timescale 1ns/100ps
module rtcif_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q;
        logic s2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= async_i[i];
                s2_q <= s1_q;
            end
        end

        assign sync_o[i] = s2_q;
    end

endmodule

// File: rtl/rtcif_keyseq.sv
`timescale 1ns/100ps
module rtcif_keyseq
    import rtcif_pkg::*;
#(
    parameter logic [7:0] KEY_A = KEY_FIRST,
    parameter logic [7:0] KEY_B = KEY_SECOND
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       key_sel,
    input  logic [7:0] key_byte,
    output logic       unlocked
);

    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (key_sel) begin
                if (key_byte == KEY_A) begin
                    state_d = KS_HALF;
                end else if (state_q == KS_HALF && key_byte == KEY_B) begin
                    state_d = KS_OPEN;
                end else begin
                    state_d = KS_LOCKED;
                end
            end else if (state_q == KS_HALF) begin
                // Any other bus write breaks the pair
                state_d = KS_LOCKED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/rtcif_rtc_side.sv
`timescale 1ns/100ps
module rtcif_rtc_side #(
    parameter int TIME_W = 23,
    parameter int DATE_W = 24
) (
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic              init_req,
    input  logic              ref_tgl,
    input  logic [TIME_W-1:0] cnt_time,
    input  logic [DATE_W-1:0] cnt_date,
    output logic              act,
    output logic              load,
    output logic              ack_tgl,
    output logic [TIME_W-1:0] shd_time,
    output logic [DATE_W-1:0] shd_date
);

    typedef struct packed {
        logic              act_p1;
        logic              act;
        logic              load;
        logic              seen;
        logic [TIME_W-1:0] shd_time;
        logic [DATE_W-1:0] shd_date;
    } rtc_st_t;

    rtc_st_t    d, q;
    logic [1:0] in_s;
    logic       req_s;
    logic       ref_s;
    logic       pending;
    logic       quiet;

    rtcif_sync2 #(.W(2), .RST_VAL(2'b00)) u_sync_in (
        .clk     (rtc_clk),
        .rst_n   (rtc_rst_n),
        .async_i ({init_req, ref_tgl}),
        .sync_o  (in_s)
    );

    assign req_s = in_s[1];
    assign ref_s = in_s[0];

    always_comb begin
        d        = q;
        d.act_p1 = req_s;
        d.act    = q.act_p1;
        // Strobe on the edge where init-active drops
        d.load   = q.act & ~q.act_p1;
        pending  = ref_s ^ q.seen;
        quiet    = ~q.act & ~q.act_p1 & ~q.load;
        if (pending && quiet) begin
            d.shd_time = cnt_time;
            d.shd_date = cnt_date;
            d.seen     = ref_s;
        end
    end

    always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign act      = q.act;
    assign load     = q.load;
    assign ack_tgl  = q.seen;
    assign shd_time = q.shd_time;
    assign shd_date = q.shd_date;

endmodule

// File: rtl/rtcif_top.sv
`timescale 1ns/100ps
module rtcif_top
    import rtcif_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter int              DATA_W   = 32,
    parameter int              TIME_W   = 23,
    parameter int              DATE_W   = 24,
    parameter int              PRE_W    = 23,
    parameter logic [PRE_W-1:0] PRE_RST = 23'h7F00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [TIME_W-1:0] cal_time,
    output logic [DATE_W-1:0] cal_date,
    output logic [PRE_W-1:0]  cal_prescale,
    output logic              cal_fmt12,
    output logic              cal_load,
    output logic              cal_freeze,
    input  logic [TIME_W-1:0] cnt_time,
    input  logic [DATE_W-1:0] cnt_date
);

    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(OFS_PRE);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
    localparam int                YEAR_LSB = DATE_W - 8;

    typedef struct packed {
        logic              init_req;
        logic              rsf;
        logic              ref_tgl;
        logic              initf_prev;
        logic [TIME_W-1:0] tm;
        logic [DATE_W-1:0] dt;
        logic [PRE_W-1:0]  pre;
        logic              fmt12;
    } bus_st_t;

    bus_st_t           d, q;
    logic              unlocked;
    logic [1:0]        back_s;
    logic              initf_now;
    logic              ack_now;
    logic              act_rtc;
    logic              ack_rtc;
    logic [TIME_W-1:0] shd_time;
    logic [DATE_W-1:0] shd_date;
    logic              inits;
    logic              sel_time, sel_date, sel_stat, sel_pre, sel_ctrl, sel_key;
    logic              wr_open;
    logic              cal_open;
    logic              initf_fall;
    logic              refresh_start;

    // Signals brought out by name for the bound checker
    logic              st_req;
    logic              st_rsf;
    logic [TIME_W-1:0] st_time;
    logic [DATE_W-1:0] st_date;

    assign sel_time = (bus_addr == A_TIME);
    assign sel_date = (bus_addr == A_DATE);
    assign sel_stat = (bus_addr == A_STAT);
    assign sel_pre  = (bus_addr == A_PRE);
    assign sel_ctrl = (bus_addr == A_CTRL);
    assign sel_key  = (bus_addr == A_KEY);

    rtcif_keyseq #(.KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .key_sel  (sel_key),
        .key_byte (bus_wdata[7:0]),
        .unlocked (unlocked)
    );

    rtcif_rtc_side #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_rtc_side (
        .rtc_clk   (rtc_clk),
        .rtc_rst_n (rtc_rst_n),
        .init_req  (q.init_req),
        .ref_tgl   (q.ref_tgl),
        .cnt_time  (cnt_time),
        .cnt_date  (cnt_date),
        .act       (act_rtc),
        .load      (cal_load),
        .ack_tgl   (ack_rtc),
        .shd_time  (shd_time),
        .shd_date  (shd_date)
    );

    rtcif_sync2 #(.W(2), .RST_VAL(2'b00)) u_sync_back (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({act_rtc, ack_rtc}),
        .sync_o  (back_s)
    );

    assign initf_now = back_s[1];
    assign ack_now   = back_s[0];
    assign inits     = |shd_date[DATE_W-1:YEAR_LSB];

    always_comb begin
        d            = q;
        d.initf_prev = initf_now;
        wr_open      = bus_wr & unlocked;
        cal_open     = wr_open & initf_now & q.init_req;
        initf_fall   = q.initf_prev & ~initf_now;

        if (wr_open && sel_stat) d.init_req = bus_wdata[STAT_REQ_BIT];
        if (wr_open && sel_ctrl) d.fmt12    = bus_wdata[CTRL_FMT_BIT];
        if (cal_open && sel_time) d.tm      = bus_wdata[TIME_W-1:0];
        if (cal_open && sel_date) d.dt      = bus_wdata[DATE_W-1:0];
        if (cal_open && sel_pre)  d.pre     = bus_wdata[PRE_W-1:0];

        refresh_start = (wr_open & sel_stat & ~bus_wdata[STAT_SYNC_BIT]) | initf_fall;
        if (refresh_start) begin
            d.rsf = 1'b0;
            // Only one refresh in flight; a second start folds into it
            if (ack_now == q.ref_tgl) d.ref_tgl = ~q.ref_tgl;
        end else if (ack_now == q.ref_tgl) begin
            d.rsf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.ref_tgl    <= 1'b1;
            q.pre        <= PRE_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_time) begin
            bus_rdata[TIME_W-1:0] = shd_time;
        end else if (sel_date) begin
            bus_rdata[DATE_W-1:0] = shd_date;
        end else if (sel_stat) begin
            bus_rdata[STAT_REQ_BIT]  = q.init_req;
            bus_rdata[STAT_ACT_BIT]  = initf_now;
            bus_rdata[STAT_SYNC_BIT] = q.rsf;
            bus_rdata[STAT_SET_BIT]  = inits;
        end else if (sel_pre) begin
            bus_rdata[PRE_W-1:0] = q.pre;
        end else if (sel_ctrl) begin
            bus_rdata[CTRL_FMT_BIT] = q.fmt12;
        end
    end

    assign cal_time     = q.tm;
    assign cal_date     = q.dt;
    assign cal_prescale = q.pre;
    assign cal_fmt12    = q.fmt12;
    assign cal_freeze   = act_rtc;

    assign st_req  = q.init_req;
    assign st_rsf  = q.rsf;
    assign st_time = q.tm;
    assign st_date = q.dt;

endmodule

// File: rtl/rtcif_checker.sv
`timescale 1ns/100ps
module rtcif_checker
    import rtcif_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int TIME_W = 23,
    parameter int DATE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rtc_clk,
    input logic              rtc_rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              unlocked,
    input logic              initf,
    input logic              init_req,
    input logic              rsf,
    input logic [TIME_W-1:0] time_r,
    input logic [DATE_W-1:0] date_r,
    input logic              cal_load,
    input logic              cal_freeze
);

    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

    assert_unlock_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == A_KEY && bus_wdata[7:0] == KEY_SECOND));

    assert_key_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_KEY && bus_wdata[7:0] != KEY_FIRST && bus_wdata[7:0] != KEY_SECOND)
        |=> !unlocked);

    assert_locked_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TIME && !unlocked) |=> $stable(time_r));

    assert_date_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATE && !(unlocked && initf && init_req)) |=> $stable(date_r));

    assert_sync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unlocked && bus_addr == A_STAT && !bus_wdata[STAT_SYNC_BIT]) |=> !rsf);

    assert_load_unfrozen_R8: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        cal_load |-> !cal_freeze);

endmodule

bind rtcif_top rtcif_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TIME_W (TIME_W),
    .DATE_W (DATE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rtc_clk    (rtc_clk),
    .rtc_rst_n  (rtc_rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .unlocked   (unlocked),
    .initf      (initf_now),
    .init_req   (st_req),
    .rsf        (st_rsf),
    .time_r     (st_time),
    .date_r     (st_date),
    .cal_load   (cal_load),
    .cal_freeze (cal_freeze)
);

// File: tb/rtcif_top_bench.sv
`timescale 1ns/100ps
module rtcif_top_bench;

    logic        clk = 1'b0;
    logic        rtc_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [22:0] cal_time;
    logic [23:0] cal_date;
    logic [22:0] cal_prescale;
    logic        cal_fmt12;
    logic        cal_load;
    logic        cal_freeze;
    logic [22:0] cnt_time;
    logic [23:0] cnt_date;

    int n_chk  = 0;
    int n_fail = 0;
    int n_load = 0;
    logic [22:0] ld_time;
    logic [23:0] ld_date;

    always #2.5 clk = ~clk;       // 200 MHz bus clock
    always #18.5 rtc_clk = ~rtc_clk;

    rtcif_top u_rtcif_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .rtc_clk      (rtc_clk),
        .rtc_rst_n    (rtc_rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .cal_time     (cal_time),
        .cal_date     (cal_date),
        .cal_prescale (cal_prescale),
        .cal_fmt12    (cal_fmt12),
        .cal_load     (cal_load),
        .cal_freeze   (cal_freeze),
        .cnt_time     (cnt_time),
        .cnt_date     (cnt_date)
    );

    // Calendar counter model: time counts per RTC cycle unless frozen
    always @(posedge rtc_clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) begin
            cnt_time <= '0;
            cnt_date <= '0;
            ld_time  <= '0;
            ld_date  <= '0;
            n_load   <= 0;
        end else if (cal_load) begin
            cnt_time <= cal_time;
            cnt_date <= cal_date;
            ld_time  <= cal_time;
            ld_date  <= cal_date;
            n_load   <= n_load + 1;
        end else if (!cal_freeze) begin
            cnt_time <= cnt_time + 23'd1;
        end
    end

    // {op(0 write,1 read), addr, data, expected, requirement number}
    localparam int NV = 38;
    localparam logic [77:0] VEC [NV] = '{
        {2'd1, 8'h18, 32'h0,        32'h0,        4'd1},   // R1 control reset
        {2'd1, 8'h10, 32'h0,        32'h007F00FF, 4'd1},   // R1 prescaler reset
        {2'd1, 8'h0C, 32'h0,        32'h00000020, 4'd9},   // R9 year 0 -> bit 4 clear
        {2'd0, 8'h18, 32'h40,       32'h0,        4'd4},
        {2'd1, 8'h18, 32'h0,        32'h0,        4'd4},   // R4 locked control
        {2'd0, 8'h10, 32'h1234,     32'h0,        4'd4},
        {2'd1, 8'h10, 32'h0,        32'h007F00FF, 4'd4},   // R4 locked prescaler
        {2'd0, 8'h24, 32'hCA,       32'h0,        4'd2},
        {2'd0, 8'h24, 32'h53,       32'h0,        4'd2},
        {2'd0, 8'h18, 32'h40,       32'h0,        4'd2},
        {2'd1, 8'h18, 32'h0,        32'h40,       4'd2},   // R2 unlocked write lands
        {2'd0, 8'h18, 32'hFFFFFFFF, 32'h0,        4'd10},
        {2'd1, 8'h18, 32'h0,        32'h40,       4'd10},  // R10 only bit 6 kept
        {2'd0, 8'h10, 32'h1234,     32'h0,        4'd5},
        {2'd1, 8'h10, 32'h0,        32'h007F00FF, 4'd5},   // R5 no init window
        {2'd0, 8'h24, 32'hFF,       32'h0,        4'd3},
        {2'd0, 8'h18, 32'h0,        32'h0,        4'd3},
        {2'd1, 8'h18, 32'h0,        32'h40,       4'd3},   // R3 relocked
        {2'd0, 8'h24, 32'hCA,       32'h0,        4'd2},
        {2'd0, 8'h18, 32'h0,        32'h0,        4'd2},
        {2'd0, 8'h24, 32'h53,       32'h0,        4'd2},
        {2'd0, 8'h18, 32'h0,        32'h0,        4'd2},
        {2'd1, 8'h18, 32'h0,        32'h40,       4'd2},   // R2 broken pair
        {2'd0, 8'h24, 32'h53,       32'h0,        4'd2},
        {2'd0, 8'h24, 32'hCA,       32'h0,        4'd2},
        {2'd0, 8'h18, 32'h0,        32'h0,        4'd2},
        {2'd1, 8'h18, 32'h0,        32'h40,       4'd2},   // R2 wrong order
        {2'd0, 8'h24, 32'hCA,       32'h0,        4'd2},
        {2'd0, 8'h24, 32'hCA,       32'h0,        4'd2},
        {2'd0, 8'h24, 32'h53,       32'h0,        4'd2},
        {2'd0, 8'h18, 32'h0,        32'h0,        4'd2},
        {2'd1, 8'h18, 32'h0,        32'h0,        4'd2},   // R2 repeated first key
        {2'd1, 8'h24, 32'h0,        32'h0,        4'd11},  // R11 key reads 0
        {2'd1, 8'h08, 32'h0,        32'h0,        4'd11},  // R11 unmapped
        {2'd1, 8'h3C, 32'h0,        32'h0,        4'd11},  // R11 unmapped
        {2'd0, 8'h24, 32'hFF,       32'h0,        4'd4},
        {2'd0, 8'h0C, 32'h80,       32'h0,        4'd4},
        {2'd1, 8'h0C, 32'h0,        32'h00000020, 4'd4}    // R4 locked status
    };

    task automatic do_wr(input logic [7:0] a, input logic [31:0] dv);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a[5:0];
        bus_wdata = dv;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a[5:0];
        #1;
        v = bus_rdata;
    endtask

    task automatic chk(input bit ok, input string rid, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rid, act, exp);
        end
    endtask

    task automatic wait_stat(input int b, input logic val, output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 800; i++) begin
            do_rd(8'h0C, v);
            if (v[b] == val) begin
                ok = 1'b1;
                return;
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] t1;
        logic [31:0] t2;
        logic [77:0] e;
        bit          ok;

        repeat (10) @(negedge clk);
        rst_n     = 1'b1;
        rtc_rst_n = 1'b1;

        do_rd(8'h0C, v);
        chk(v == 32'h0, "R1 status after reset", v, 32'h0);
        wait_stat(5, 1'b1, ok);
        chk(ok, "R1 first refresh sets sync flag", {31'b0, ok}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            e = VEC[i];
            if (e[77:76] == 2'd0) begin
                do_wr(e[75:68], e[67:36]);
            end else begin
                do_rd(e[75:68], v);
                chk(v == e[35:4], $sformatf("R%0d table entry %0d", e[3:0], i), v, e[35:4]);
            end
        end

        // R10 format output
        @(negedge clk);
        chk(cal_fmt12 == 1'b0, "R10 fmt output low", {31'b0, cal_fmt12}, 32'h0);
        do_wr(8'h24, 32'hCA);
        do_wr(8'h24, 32'h53);
        do_wr(8'h18, 32'h40);
        @(negedge clk);
        chk(cal_fmt12 == 1'b1, "R10 fmt output high", {31'b0, cal_fmt12}, 32'h1);
        do_wr(8'h18, 32'h0);

        // R6 init handshake
        do_wr(8'h0C, 32'hA0);
        do_rd(8'h0C, v);
        chk(v[6] == 1'b0, "R6 active not yet set", v, 32'h80);
        wait_stat(6, 1'b1, ok);
        chk(ok, "R6 active rises", {31'b0, ok}, 32'h1);
        @(negedge clk);
        chk(cal_freeze == 1'b1, "R6 freeze high in init", {31'b0, cal_freeze}, 32'h1);
        do_rd(8'h0C, v);
        chk(v == 32'hE0, "R6 status in init", v, 32'hE0);

        // R5 writes inside the init window
        do_wr(8'h10, 32'h00030010);
        do_rd(8'h10, v);
        chk(v == 32'h00030010, "R5 prescaler accepted", v, 32'h00030010);
        do_wr(8'h00, 32'h00123456);
        do_wr(8'h04, 32'h00190101);
        @(negedge clk);
        chk(cal_time == 23'h123456, "R5 time accepted", {9'b0, cal_time}, 32'h00123456);
        chk(cal_date == 24'h190101, "R5 date accepted", {8'b0, cal_date}, 32'h00190101);
        chk(n_load == 0, "R8 no load during init", n_load, 32'h0);

        // R8 exit init, load, resync
        do_wr(8'h0C, 32'h00);
        do_rd(8'h0C, v);
        chk(v[5] == 1'b0 && v[7] == 1'b0, "R7 sync flag cleared on write", v, 32'h40);
        wait_stat(6, 1'b0, ok);
        chk(ok, "R6 active drops", {31'b0, ok}, 32'h1);
        wait_stat(5, 1'b1, ok);
        chk(ok, "R8 sync flag after exit", {31'b0, ok}, 32'h1);
        chk(n_load == 1, "R8 single load strobe", n_load, 32'h1);
        chk(ld_time == 23'h123456 && ld_date == 24'h190101, "R8 loaded values",
            {9'b0, ld_time}, 32'h00123456);
        do_rd(8'h00, t1);
        chk(t1 >= 32'h00123456 && t1 <= 32'h00123456 + 32'd40, "R8 time readback after load",
            t1, 32'h00123456);
        do_rd(8'h04, v);
        chk(v == 32'h00190101, "R8 date readback", v, 32'h00190101);
        do_rd(8'h0C, v);
        chk(v == 32'h30, "R9 year nonzero sets bit 4", v, 32'h30);

        // R7 write with bit 5 set keeps the flag, write with 0 refreshes
        do_wr(8'h0C, 32'h20);
        do_rd(8'h0C, v);
        chk(v[5] == 1'b1, "R7 bit 5 one keeps flag", v, 32'h30);
        repeat (100) @(negedge clk);
        do_wr(8'h0C, 32'h00);
        do_rd(8'h0C, v);
        chk(v[5] == 1'b0, "R7 flag cleared", v, 32'h10);
        wait_stat(5, 1'b1, ok);
        chk(ok, "R7 flag sets after refresh", {31'b0, ok}, 32'h1);
        do_rd(8'h00, t2);
        chk(t2 > t1, "R7 shadow refreshed", t2, t1 + 32'd1);

        // R4 locked time write ignored while counters run
        do_wr(8'h24, 32'hFF);
        do_wr(8'h00, 32'h0);
        @(negedge clk);
        chk(cal_time == 23'h123456, "R4 locked time ignored", {9'b0, cal_time}, 32'h00123456);

        summary();
        $finish;
    end

endmodule